// File: doc/BRIEF.md
# Square-Root Carry-Select Adder

This block adds two unsigned operands and a carry input, producing a sum and a carry output. It is intended as the accumulating adder inside a distributed-arithmetic transform datapath. There its width is 13 bits, and its speed matters more than its area because the surrounding logic runs at a reduced supply.

The operand is split into stages. Each stage is wider than the stage below it by one bit: the default split is 2, 3, 4 and 4 bits, from the least significant stage to the most significant. The lowest stage takes the external carry input directly. Every other stage builds two complete results in advance, one assuming a carry-in of 0 and one assuming a carry-in of 1. Each of these results uses its own carry chain. Each chain forms one carry per bit with a single generate-or-pass gate, using per-bit generate (a&b), propagate (a^b) and kill (~a&~b) terms. Each sum bit is the propagate term exclusive-ORed with the carry into that bit. When the real carry arrives from the stage below, it picks one result and one carry-out. The width grows because a later stage has more time before its select carry arrives.

The parameter `REG_OUT` selects the output. With `REG_OUT` = 1 (the default), the result is captured in an output register with a clock enable. With `REG_OUT` = 0, the adder is purely combinational.

Top module: `sqrt_csel_adder`

## Requirements
- R1: For every input combination, {cout, sum} equals the (WIDTH+1)-bit value a + b + cin, with cout as the most significant bit.
- R2: With REG_OUT=1, a rising clock edge at which en=1 and rst_n=1 loads the R1 result of the inputs present at that edge, visible on sum/cout right after the edge.
- R3: With REG_OUT=1, a rising edge at which en=0 leaves sum and cout unchanged, whatever a, b and cin are doing.
- R4: With REG_OUT=1, rst_n=0 clears sum and cout to zero at once, without waiting for a clock edge.
- R5: A carry-in of 1 added to an all-ones a and a zero b propagates through every stage: sum is all zeros and cout is 1.
- R6: When the most significant bits of a and b are both 1, cout is 1.
- R7: With REG_OUT=0, sum and cout follow a, b and cin with no clock edge needed.
- R8: Alternating operands (a = 0101…, b = 1010…) with cin=1 put every bit in propagate: sum is all zeros and cout is 1. With cin=0 they give sum all ones and cout 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| en | input | 1 | Clock enable of the output register |
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum bits |
| cout | output | 1 | Carry out of the top bit |

## Verification
A wrong chain gate or a wrong stage select leaves no hidden state behind. It shows up as a wrong sum or carry for exactly the input vectors that take that path. In the combinational variant the error appears at once; in the registered variant it appears one edge later. Errors in a select path only appear when that stage's incoming carry is 1. For that reason a small configuration is swept over every combination of a, b and cin. The 13-bit default is then driven with random vectors and with full-length propagate patterns (all ones, alternating bits) that exercise every select. A faulty enable or reset shows on the first edge after it is applied.

// File: rtl/sqrt_csel_pkg.sv
package sqrt_csel_pkg;

  // Number of stages when stage widths start at f and grow by one bit
  // per stage until w bits are covered.
  function automatic int stage_count(input int w, input int f);
    int n;
    int lo;
    int sw;
    n  = 0;
    lo = 0;
    sw = f;
    while (lo < w) begin
      lo += sw;
      sw += 1;
      n  += 1;
    end
    return n;
  endfunction

  // Lowest bit index of stage idx.
  function automatic int stage_lo(input int f, input int idx);
    int lo;
    int sw;
    lo = 0;
    sw = f;
    for (int k = 0; k < idx; k++) begin
      lo += sw;
      sw += 1;
    end
    return lo;
  endfunction

  // Width of stage idx; the last stage is clipped to what remains.
  function automatic int stage_width(input int w, input int f, input int idx);
    int lo;
    int sw;
    lo = stage_lo(f, idx);
    sw = f + idx;
    if (lo + sw > w) return w - lo;
    return sw;
  endfunction

endpackage

// File: rtl/sqcs_manchester_chain.sv
// Carry chain of one stage: one generate-or-pass gate per bit.
module sqcs_manchester_chain #(
  parameter int W = 4
) (
  input  logic [W-1:0] gen,
  input  logic [W-1:0] prp,
  input  logic [W-1:0] kil,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);

  logic [W:0] c;

  assign c[0] = ci;

  for (genvar gi = 0; gi < W; gi++) begin : g_bit
    // A bit that does not kill passes its incoming carry on;
    // a generating bit forces a carry.
    assign c[gi+1] = gen[gi] | (~kil[gi] & c[gi]);
  end

  assign s  = prp ^ c[W-1:0];
  assign co = c[W];

endmodule

// File: rtl/sqcs_select_stage.sv
// One stage: either a single chain fed by the real carry, or two
// precomputed chains and a select on the arriving carry.
module sqcs_select_stage #(
  parameter int W          = 4,
  parameter int HAS_SELECT = 1
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);

  logic [W-1:0] gen;
  logic [W-1:0] prp;
  logic [W-1:0] kil;

  assign gen = a & b;
  assign prp = a ^ b;
  assign kil = ~(a | b);

  if (HAS_SELECT == 0) begin : g_direct
    sqcs_manchester_chain #(.W(W)) u_chain (
      .gen(gen), .prp(prp), .kil(kil), .ci(ci), .s(s), .co(co)
    );
  end else begin : g_select
    logic [W-1:0] s_c0;
    logic [W-1:0] s_c1;
    logic         co_c0;
    logic         co_c1;

    sqcs_manchester_chain #(.W(W)) u_chain_c0 (
      .gen(gen), .prp(prp), .kil(kil), .ci(1'b0), .s(s_c0), .co(co_c0)
    );
    sqcs_manchester_chain #(.W(W)) u_chain_c1 (
      .gen(gen), .prp(prp), .kil(kil), .ci(1'b1), .s(s_c1), .co(co_c1)
    );

    always_comb begin
      if (ci) begin
        s  = s_c1;
        co = co_c1;
      end else begin
        s  = s_c0;
        co = co_c0;
      end
    end
  end

endmodule

// File: rtl/sqrt_csel_adder.sv
module sqrt_csel_adder
  import sqrt_csel_pkg::*;
#(
  parameter int WIDTH   = 13,
  parameter int FIRST_W = 2,
  parameter int REG_OUT = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);

  localparam int NSTG = stage_count(WIDTH, FIRST_W);

  logic [WIDTH-1:0] sum_c;
  logic [NSTG:0]    stc;

  assign stc[0] = cin;

  for (genvar gs = 0; gs < NSTG; gs++) begin : g_stage
    localparam int LO = stage_lo(FIRST_W, gs);
    localparam int SW = stage_width(WIDTH, FIRST_W, gs);
    localparam int HS = (gs == 0) ? 0 : 1;

    sqcs_select_stage #(.W(SW), .HAS_SELECT(HS)) u_stage (
      .a  (a[LO +: SW]),
      .b  (b[LO +: SW]),
      .ci (stc[gs]),
      .s  (sum_c[LO +: SW]),
      .co (stc[gs+1])
    );
  end

  if (REG_OUT != 0) begin : g_reg
    logic [WIDTH-1:0] sum_q;
    logic [WIDTH-1:0] sum_d;
    logic             cout_q;
    logic             cout_d;

    always_comb begin
      sum_d  = sum_q;
      cout_d = cout_q;
      if (en) begin
        sum_d  = sum_c;
        cout_d = stc[NSTG];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sum_q  <= '0;
        cout_q <= 1'b0;
      end else begin
        sum_q  <= sum_d;
        cout_q <= cout_d;
      end
    end

    assign sum  = sum_q;
    assign cout = cout_q;
  end else begin : g_comb
    assign sum  = sum_c;
    assign cout = stc[NSTG];
  end

endmodule

// File: rtl/sqrt_csel_adder_checker.sv
module sqrt_csel_adder_checker #(
  parameter int WIDTH   = 13,
  parameter int REG_OUT = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic             cin,
  input logic [WIDTH-1:0] sum,
  input logic             cout
);

  logic [WIDTH:0] ref_total;
  assign ref_total = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};

  if (REG_OUT != 0) begin : g_reg_chk
    // R2: an enabled edge loads the arithmetic result
    p_load_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(en)) |-> ({cout, sum} == $past(ref_total)));

    // R3: a disabled edge holds the outputs
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(en)) |-> $stable({cout, sum}));

    // R6: both MSBs set must carry out
    p_msb_generate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(en) && $past(a[WIDTH-1] & b[WIDTH-1])) |-> cout);

    // R4: outputs are clear while reset is low
    always @(posedge clk) begin
      if (!rst_n) begin
        p_reset_clear_r4: assert (sum == '0 && cout == 1'b0);
      end
    end
  end

endmodule

bind sqrt_csel_adder sqrt_csel_adder_checker #(
  .WIDTH(WIDTH), .REG_OUT(REG_OUT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .a(a), .b(b), .cin(cin),
  .sum(sum), .cout(cout)
);

// File: tb/sqrt_csel_adder_bench.sv
module sqrt_csel_adder_bench;

  localparam int W  = 13;
  localparam int SW = 6;

  logic          clk;
  logic          rst_n;
  logic          en;
  logic [W-1:0]  a, b;
  logic          cin;
  logic [W-1:0]  sum;
  logic          cout;

  logic [SW-1:0] sa, sb;
  logic          scin;
  logic [SW-1:0] ssum;
  logic          scout;

  int checks   = 0;
  int failures = 0;

  sqrt_csel_adder #(.WIDTH(W), .FIRST_W(2), .REG_OUT(1)) u_sqrt_csel_adder (
    .clk(clk), .rst_n(rst_n), .en(en), .a(a), .b(b), .cin(cin),
    .sum(sum), .cout(cout)
  );

  // Small combinational configuration (stages 2,3,1) for exhaustive sweep.
  sqrt_csel_adder #(.WIDTH(SW), .FIRST_W(2), .REG_OUT(0)) u_sqrt_csel_adder_small (
    .clk(clk), .rst_n(rst_n), .en(en), .a(sa), .b(sb), .cin(scin),
    .sum(ssum), .cout(scout)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [W:0] act, input logic [W:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W:0] total(input logic [W-1:0] x, input logic [W-1:0] y,
                                       input logic c);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
  endfunction

  // Drive at negedge, clock once, sample 1 ns after the edge.
  task automatic load(input logic [W-1:0] x, input logic [W-1:0] y, input logic c,
                      input string req);
    @(negedge clk);
    a = x; b = y; cin = c; en = 1'b1;
    @(posedge clk);
    #1;
    chk(req, {cout, sum}, total(x, y, c));
  endtask

  initial begin
    #(10 * 190000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [W:0] held;
    rst_n = 1'b0; en = 1'b0; a = '0; b = '0; cin = 1'b0;
    sa = '0; sb = '0; scin = 1'b0;

    // R7 / R1: exhaustive sweep of the small combinational instance
    for (int v = 0; v < (1 << (2 * SW + 1)); v++) begin
      logic [12:0] vv;
      vv = v[12:0];
      {sa, sb, scin} = vv;
      #1;
      chk("R7 R1 small", {{(W-SW){1'b0}}, scout, ssum},
          {{(W-SW){1'b0}}, ({1'b0, sa} + {1'b0, sb} + {{SW{1'b0}}, scin})});
    end

    // R4: reset state
    repeat (3) @(posedge clk);
    #1;
    chk("R4 reset state", {cout, sum}, '0);
    @(negedge clk);
    rst_n = 1'b1;

    // R5: full carry propagation from cin
    load({W{1'b1}}, '0, 1'b1, "R5 cin ripple");
    chk("R5 zero sum", {cout, sum}, {1'b1, {W{1'b0}}});
    // R6: MSB generate
    load({1'b1, {(W-1){1'b0}}}, {1'b1, {(W-1){1'b0}}}, 1'b0, "R6 msb gen");
    chk("R6 cout", {{W{1'b0}}, cout}, {{W{1'b0}}, 1'b1});
    // R8: alternating patterns
    load({(W+1)/2{2'b01}}, {(W+1)/2{2'b10}}, 1'b1, "R8 alt cin1");
    chk("R8 alt cin1 value", {cout, sum}, {1'b1, {W{1'b0}}});
    load({(W+1)/2{2'b10}}, {(W+1)/2{2'b01}}, 1'b0, "R8 alt cin0");
    chk("R8 alt cin0 value", {cout, sum}, {1'b0, {W{1'b1}}});
    load({W{1'b1}}, {W{1'b1}}, 1'b1, "R1 all ones");
    load('0, '0, 1'b0, "R1 all zeros");

    // R2 / R1: random vectors through the register
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      load(r[W-1:0], r[2*W-1:W], r[31], "R2 random");
    end

    // R3: enable low holds outputs while inputs change
    load(13'h0abc, 13'h0123, 1'b1, "R2 before hold");
    held = {cout, sum};
    for (int i = 0; i < 5; i++) begin
      logic [31:0] r;
      r = $urandom;
      @(negedge clk);
      en = 1'b0; a = r[W-1:0]; b = r[2*W-1:W]; cin = ~cin;
      @(posedge clk);
      #1;
      chk("R3 hold", {cout, sum}, held);
    end

    // R4: asynchronous clear between edges
    load({W{1'b1}}, 13'h0001, 1'b0, "R2 before reset");
    @(negedge clk);
    #2;
    rst_n = 1'b0;
    #1;
    chk("R4 async clear", {cout, sum}, '0);
    @(negedge clk);
    rst_n = 1'b1;
    load(13'h1555, 13'h0aaa, 1'b1, "R2 after reset");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule